// File: doc/BRIEF.md
# Single-Phase PCI Target Handshake Responder

This block is the smallest useful target on a 32-bit, 33 MHz PCI bus. It watches every address phase, and it claims a transaction only when the captured command is an I/O or memory read or write and the captured address falls inside a fixed window. A claimed transaction gets exactly one data phase. The block signals it with only two bus outputs: the device-select strobe (DEVSEL#) and the target-ready strobe (TRDY#). It never drives the address/data lines, has no configuration registers and no parity logic. The block is a first bring-up step for a custom target: it shows that the claim and handshake timing is sound before any data path is added.

All bus inputs are sampled on the rising clock edge and both outputs come straight from flip-flops. Each output has its own output enable, so a pad can tri-state it. When a data phase ends, the block drives both strobes high for one clock before it releases the enables. This follows the sustained tri-state rule.

Top module: `pci_tgt_resp`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, both output enables are 0 and devsel_n and trdy_n are 1.
- R2: An address phase is recognised only on a rising edge where frame_n is 0 and the previous edge sampled frame_n = 1 and irdy_n = 1. ad and cbe_n are captured on that edge.
- R3: Only the command codes 4'b0010, 4'b0011, 4'b0110 and 4'b0111 on cbe_n during the address phase can claim. Any other code, such as 4'b1010 or 4'b1100, leaves both enables at 0 for the whole transaction.
- R4: The address hits when (ad & WIN_MASK) == (WIN_BASE & WIN_MASK). With the defaults, the window is 0x4000_0000 to 0x4000_0FFF. A miss leaves both enables at 0.
- R5: On a claim, the clock after the address phase shows devsel_n = 0 and trdy_n = 1, with both enables at 1.
- R6: One clock after DEVSEL# goes low, trdy_n goes to 0 while devsel_n stays 0.
- R7: While TRDY# is low and irdy_n is sampled 1, both strobes stay low (wait states).
- R8: On the first edge where irdy_n is sampled 0 while trdy_n is 0, the next clock shows devsel_n = 1 and trdy_n = 1, with both enables still at 1.
- R9: After that single clock of driving the strobes high, both enables return to 0.
- R10: While a handshake is in progress, an idle-then-FRAME#-low pattern on the bus does not restart the block. The handshake goes on as if that pattern had not happened.
- R11: A new hit that starts one clock after the enables are released is claimed with the same timing as the first one.
- R12: trdy_n is never driven low unless devsel_n is driven low in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Cycle-frame strobe from the initiator, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| ad | input | 32 | Multiplexed address/data lines (only ever read) |
| cbe_n | input | 4 | Command / byte-enable lines, active low |
| devsel_n | output | 1 | Device-select strobe value |
| devsel_oe | output | 1 | Output enable for devsel_n |
| trdy_n | output | 1 | Target-ready strobe value |
| trdy_oe | output | 1 | Output enable for trdy_n |

## Verification
The main function is tried with hits that have zero, one and several initiator wait states. These separate a responder that releases on the right IRDY# edge from one that releases on a fixed count. Misses by address just past the upper edge of the window, just below its base, and by commands outside the accepted set check that the decode uses both fields. A bare idle-then-FRAME# pattern during an open handshake, and a hit placed one clock after the release, separate a block that locks out new address phases from one that restarts or stalls.

// File: rtl/pci_resp_pkg.sv
package pci_resp_pkg;

  localparam int unsigned PCI_AD_W  = 32;
  localparam int unsigned PCI_CMD_W = 4;
  localparam int unsigned N_LANES   = 2;   // lane 0: device select, lane 1: target ready
  localparam int unsigned LANE_DEV  = 0;
  localparam int unsigned LANE_RDY  = 1;

  typedef enum logic [2:0] {
    HS_IDLE  = 3'd0,
    HS_ADDR  = 3'd1,
    HS_CLAIM = 3'd2,
    HS_DATA  = 3'd3,
    HS_REL   = 3'd4
  } hs_state_e;

  // Command codes this target answers: I/O and memory, read and write.
  function automatic logic cmd_accepted(input logic [PCI_CMD_W-1:0] cmd);
    case (cmd)
      4'b0010, 4'b0011, 4'b0110, 4'b0111: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic addr_in_window(input logic [PCI_AD_W-1:0] a,
                                          input logic [PCI_AD_W-1:0] base,
                                          input logic [PCI_AD_W-1:0] mask);
    return ((a & mask) == (base & mask));
  endfunction

  // Strobe level for a lane in a given state: 1 means drive low.
  function automatic logic lane_low(input hs_state_e s, input int unsigned lane);
    if (lane == LANE_DEV) return (s == HS_CLAIM) || (s == HS_DATA);
    else                  return (s == HS_DATA);
  endfunction

  // Both lanes are driven from claim through the one-clock release.
  function automatic logic lane_driven(input hs_state_e s);
    return (s == HS_CLAIM) || (s == HS_DATA) || (s == HS_REL);
  endfunction

endpackage

// File: rtl/pci_addr_capture.sv
module pci_addr_capture
  import pci_resp_pkg::*;
#(
  parameter logic [PCI_AD_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter logic [PCI_AD_W-1:0] WIN_MASK = 32'hFFFF_F000
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [PCI_AD_W-1:0]  ad,
  input  logic [PCI_CMD_W-1:0] cbe_n,
  input  logic                 fsm_idle,
  output logic                 addr_start,
  output logic                 addr_hit
);

  logic                 frame_prev_q;
  logic                 irdy_prev_q;
  logic [PCI_AD_W-1:0]  ad_q;
  logic [PCI_CMD_W-1:0] cmd_q;
  logic                 bus_was_idle;

  assign bus_was_idle = frame_prev_q && irdy_prev_q;
  assign addr_start   = fsm_idle && !frame_n && bus_was_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_prev_q <= 1'b1;
      irdy_prev_q  <= 1'b1;
    end else begin
      frame_prev_q <= frame_n;
      irdy_prev_q  <= irdy_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_q  <= '0;
      cmd_q <= '1;
    end else if (addr_start) begin
      ad_q  <= ad;
      cmd_q <= cbe_n;
    end
  end

  assign addr_hit = cmd_accepted(cmd_q) && addr_in_window(ad_q, WIN_BASE, WIN_MASK);

endmodule

// File: rtl/pci_hs_fsm.sv
module pci_hs_fsm
  import pci_resp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      addr_start,
  input  logic      addr_hit,
  input  logic      irdy_n,
  output hs_state_e state_q,
  output hs_state_e state_next,
  output logic      fsm_idle,
  output logic      claim_evt,
  output logic      phase_done
);

  assign fsm_idle   = (state_q == HS_IDLE);
  assign claim_evt  = (state_q == HS_ADDR) && addr_hit;
  assign phase_done = (state_q == HS_DATA) && !irdy_n;

  always_comb begin
    state_next = state_q;
    case (state_q)
      HS_IDLE:  if (addr_start) state_next = HS_ADDR;
      HS_ADDR:  state_next = claim_evt ? HS_CLAIM : HS_IDLE;
      HS_CLAIM: state_next = HS_DATA;
      HS_DATA:  if (phase_done) state_next = HS_REL;
      HS_REL:   state_next = HS_IDLE;
      default:  state_next = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_next;
  end

endmodule

// File: rtl/pci_drv_stage.sv
module pci_drv_stage
  import pci_resp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  hs_state_e          state_next,
  output logic [N_LANES-1:0] lane_n,
  output logic [N_LANES-1:0] lane_oe
);

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic low_w;
    logic en_w;
    assign low_w = lane_low(state_next, l);
    assign en_w  = lane_driven(state_next);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_n[l]  <= 1'b1;
        lane_oe[l] <= 1'b0;
      end else begin
        lane_n[l]  <= !low_w;
        lane_oe[l] <= en_w;
      end
    end
  end

endmodule

// File: rtl/pci_tgt_resp.sv
module pci_tgt_resp
  import pci_resp_pkg::*;
#(
  parameter logic [PCI_AD_W-1:0] WIN_BASE = 32'h4000_0000,
  parameter logic [PCI_AD_W-1:0] WIN_MASK = 32'hFFFF_F000
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_n,
  input  logic                 irdy_n,
  input  logic [PCI_AD_W-1:0]  ad,
  input  logic [PCI_CMD_W-1:0] cbe_n,
  output logic                 devsel_n,
  output logic                 devsel_oe,
  output logic                 trdy_n,
  output logic                 trdy_oe
);

  logic               addr_start;
  logic               addr_hit;
  logic               fsm_idle;
  logic               claim_evt;
  logic               phase_done;
  hs_state_e          state_q;
  hs_state_e          state_next;
  logic [N_LANES-1:0] lane_n;
  logic [N_LANES-1:0] lane_oe;

  pci_addr_capture #(
    .WIN_BASE (WIN_BASE),
    .WIN_MASK (WIN_MASK)
  ) i_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .ad         (ad),
    .cbe_n      (cbe_n),
    .fsm_idle   (fsm_idle),
    .addr_start (addr_start),
    .addr_hit   (addr_hit)
  );

  pci_hs_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_start (addr_start),
    .addr_hit   (addr_hit),
    .irdy_n     (irdy_n),
    .state_q    (state_q),
    .state_next (state_next),
    .fsm_idle   (fsm_idle),
    .claim_evt  (claim_evt),
    .phase_done (phase_done)
  );

  pci_drv_stage i_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_next (state_next),
    .lane_n     (lane_n),
    .lane_oe    (lane_oe)
  );

  assign devsel_n  = lane_n[LANE_DEV];
  assign devsel_oe = lane_oe[LANE_DEV];
  assign trdy_n    = lane_n[LANE_RDY];
  assign trdy_oe   = lane_oe[LANE_RDY];

endmodule

// File: rtl/pci_tgt_resp_chk.sv
module pci_tgt_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic irdy_n,
  input logic claim_evt,
  input logic phase_done,
  input logic devsel_n,
  input logic devsel_oe,
  input logic trdy_n,
  input logic trdy_oe
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!devsel_oe && !trdy_oe && devsel_n && trdy_n));

  a_r5_claim_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    claim_evt |=> (devsel_oe && !devsel_n && trdy_oe && trdy_n));

  a_r6_trdy_follows_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trdy_n) |-> ($past(devsel_oe) && !$past(devsel_n)));

  a_r7_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n && irdy_n) |=> (!trdy_n && !devsel_n));

  a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n && !irdy_n) |=> (trdy_n && devsel_n && trdy_oe && devsel_oe));

  a_r8_done_seen: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> (trdy_oe && !trdy_n));

  a_r9_oe_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_oe) |-> ($past(devsel_n) && $past(trdy_n)));

  a_r12_trdy_needs_devsel: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy_oe && !trdy_n) |-> (devsel_oe && !devsel_n));

endmodule

bind pci_tgt_resp pci_tgt_resp_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irdy_n     (irdy_n),
  .claim_evt  (claim_evt),
  .phase_done (phase_done),
  .devsel_n   (devsel_n),
  .devsel_oe  (devsel_oe),
  .trdy_n     (trdy_n),
  .trdy_oe    (trdy_oe)
);

// File: tb/test_pci_tgt_resp.sv
`timescale 1ns/1ps
module test_pci_tgt_resp;

  // Expected output word: {devsel_oe, devsel_n, trdy_oe, trdy_n}
  localparam logic [3:0] E_OFF = 4'b0101;
  localparam logic [3:0] E_DEV = 4'b1011;
  localparam logic [3:0] E_DAT = 4'b1010;
  localparam logic [3:0] E_REL = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = 4'hF;
  logic        devsel_n, devsel_oe, trdy_n, trdy_oe;

  int checks = 0;
  int errors = 0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  pci_tgt_resp i_pci_tgt_resp (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ad(ad), .cbe_n(cbe_n), .devsel_n(devsel_n), .devsel_oe(devsel_oe),
    .trdy_n(trdy_n), .trdy_oe(trdy_oe)
  );

  function automatic logic [3:0] outs();
    return {devsel_oe, devsel_n, trdy_oe, trdy_n};
  endfunction

  // Monitor: compares design outputs with the scoreboard after every edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (outs() !== e) begin
        errors++;
        $display("FAIL %s: got %b expected %b", t, outs(), e);
      end
      checks++;
      if (trdy_oe && !trdy_n && !(devsel_oe && !devsel_n)) begin
        errors++;
        $display("FAIL R12: got %b expected devsel driven low with trdy", outs());
      end
    end
  end

  // Driver: one bus cycle, plus the output word expected after the next edge.
  task automatic cyc(input logic f, input logic i, input logic [31:0] a,
                     input logic [3:0] c, input logic [3:0] e, input string t);
    @(negedge clk);
    frame_n = f; irdy_n = i; ad = a; cbe_n = c;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic idle(input string t);
    cyc(1'b1, 1'b1, 32'h0, 4'hF, E_OFF, t);
  endtask

  // Claimed single-phase transfer with w initiator wait states.
  task automatic hit_txn(input logic [31:0] a, input logic [3:0] c,
                         input int w, input string t_addr);
    logic [3:0] e;
    logic       irdy;
    cyc(1'b0, 1'b1, a, c, E_OFF, t_addr);
    for (int k = 1; k < 64; k++) begin
      irdy = (k > w) ? 1'b0 : 1'b1;
      if (k == 1)       e = E_DEV;
      else if (k == 2)  e = E_DAT;
      else if (!irdy)   e = E_REL;
      else              e = E_DAT;
      cyc(irdy, irdy, 32'hA5A5_0000 + k, 4'h0, e,
          (k == 1) ? "R5" : (k == 2) ? "R6" : (e == E_REL) ? "R8" : "R7");
      if (e == E_REL) break;
    end
    idle("R9");
  endtask

  // Unclaimed single-phase transfer: enables never rise.
  task automatic miss_txn(input logic [31:0] a, input logic [3:0] c, input string t);
    cyc(1'b0, 1'b1, a, c, E_OFF, t);
    cyc(1'b1, 1'b0, 32'h1234_5678, 4'h0, E_OFF, t);
    cyc(1'b1, 1'b0, 32'h1234_5678, 4'h0, E_OFF, t);
    idle(t);
    idle(t);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (outs() !== E_OFF) begin
      errors++;
      $display("FAIL R1: got %b expected %b", outs(), E_OFF);
    end
    rst_n = 1'b1;
    idle("R1");
    idle("R1");

    // Hits: each accepted command, varied wait states.
    hit_txn(32'h4000_0000, 4'b0110, 0, "R2");
    hit_txn(32'h4000_0FFC, 4'b0111, 1, "R4");
    hit_txn(32'h4000_0800, 4'b0010, 4, "R3");
    hit_txn(32'h4000_0010, 4'b0011, 2, "R3");

    // Back-to-back: second hit starts one clock after release.
    hit_txn(32'h4000_0100, 4'b0110, 0, "R11");
    hit_txn(32'h4000_0104, 4'b0111, 0, "R11");

    // Misses by address and by command.
    miss_txn(32'h4000_1000, 4'b0110, "R4");
    miss_txn(32'h3FFF_FFFC, 4'b0111, "R4");
    miss_txn(32'h4000_0000, 4'b1010, "R3");
    miss_txn(32'h4000_0000, 4'b1100, "R3");
    miss_txn(32'h4000_0000, 4'b0000, "R3");

    // Address only counts after an idle sample: FRAME# low straight after
    // a busy cycle with IRDY# low is not an address phase.
    cyc(1'b0, 1'b0, 32'h0, 4'h0, E_OFF, "R2");
    cyc(1'b0, 1'b1, 32'h4000_0000, 4'b0110, E_OFF, "R2");
    cyc(1'b1, 1'b0, 32'h0, 4'h0, E_OFF, "R2");
    idle("R2");
    idle("R2");

    // Lockout: idle then FRAME# low during an open data phase.
    cyc(1'b0, 1'b1, 32'h4000_0020, 4'b0110, E_OFF, "R2");
    cyc(1'b0, 1'b1, 32'h0, 4'h0, E_DEV, "R5");
    cyc(1'b0, 1'b1, 32'h0, 4'h0, E_DAT, "R6");
    cyc(1'b1, 1'b1, 32'h0, 4'h0, E_DAT, "R10");
    cyc(1'b0, 1'b1, 32'h4000_0040, 4'b0110, E_DAT, "R10");
    cyc(1'b0, 1'b1, 32'h0, 4'h0, E_DAT, "R10");
    cyc(1'b1, 1'b0, 32'h0, 4'h0, E_REL, "R8");
    idle("R9");
    idle("R10");

    // Miss followed by a hit once the bus is idle again.
    miss_txn(32'h8000_0000, 4'b0110, "R4");
    hit_txn(32'h4000_0200, 4'b0111, 3, "R2");

    idle("R9");
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule